// File: doc/BRIEF.md
# Packed Sum of Absolute Differences

This block takes two wide operand vectors made of unsigned byte fields and, for every 64-bit lane, adds up the absolute differences of the eight byte pairs in that lane. The total for each lane is written back into the same lane position of the result vector. Lanes never interact. With the second operand tied to zero, each lane's result is just the sum of its eight bytes. In that use the block works as an eight-way horizontal byte adder.

The datapath is a two-stage pipeline. The first stage forms the byte-wise absolute differences and registers them. The second stage reduces each lane through a chain of pairwise adds. Pairs of bytes give 16-bit field sums, pairs of those give 32-bit sums, and the last pair gives the 64-bit lane total, which is registered. A valid flag travels alongside the data. Pipeline registers load only when their stage carries valid data.

Top module: `sad_packed`

## Requirements
- R1: Each byte field is treated as an unsigned value from 0 to 255, and its absolute difference is the larger operand minus the smaller. Swapping `vec_a` and `vec_b` therefore yields the same result.
- R2: Each 64-bit lane of `out_sum` holds, in its low 11 bits, the sum of its eight byte absolute differences. The maximum is 8 × 255 = 2040. Bits 63..11 of every lane are zero.
- R3: Lane k of `out_sum` (bits 64k+63..64k) depends only on lane k of the two operands.
- R4: When `vec_b` is all zero, each lane of `out_sum` equals the sum of the eight bytes of that lane of `vec_a`.
- R5: `out_valid` is high exactly two clock cycles after `in_valid` was high. Back-to-back valid inputs produce back-to-back results in the same order.
- R6: While `rst_n` is low, `out_valid` and `out_sum` are zero.
- R7: While no valid data reaches the output stage, `out_sum` keeps its last value and `out_valid` stays low.
- R8: When `vec_a` equals `vec_b`, every lane sum is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `vec_a`/`vec_b` are valid this cycle |
| vec_a | input | VEC_W (128) | First operand, unsigned byte fields |
| vec_b | input | VEC_W (128) | Second operand, unsigned byte fields |
| out_valid | output | 1 | `out_sum` carries a new result |
| out_sum | output | VEC_W (128) | Per-lane sums, zero-extended to 64 bits |

## Verification
The embedded properties assume that `in_valid` is a clean 0 or 1 on every clock edge, including while reset is asserted. They also assume the operands are stable around the sampling edge whenever `in_valid` is high. The bench meets both assumptions by holding `in_valid` low during reset and by changing all inputs only on falling edges. Because result registers load only on valid data, the bench deliberately drops `in_valid` between and after transactions. This exercises the hold behaviour as well as the back-to-back streaming case.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int BYTE_W_DEF = 8;
  localparam int LANE_W_DEF = 64;

  // Bits needed for the sum of a lane's absolute differences
  function automatic int lane_sum_width(input int byte_w, input int lane_w);
    return byte_w + $clog2(lane_w / byte_w);
  endfunction
endpackage

// File: rtl/sad_absdiff_stage.sv
module sad_absdiff_stage #(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = sad_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  output logic              valid_q,
  output logic [VEC_W-1:0]  diff_q
);
  localparam int FIELDS = VEC_W / BYTE_W;

  // Larger minus smaller: never wraps for unsigned fields
  function automatic logic [BYTE_W-1:0] field_absdiff(input logic [BYTE_W-1:0] x,
                                                       input logic [BYTE_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic [VEC_W-1:0] diff_d;

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    assign diff_d[f*BYTE_W +: BYTE_W] = field_absdiff(a_i[f*BYTE_W +: BYTE_W],
                                                      b_i[f*BYTE_W +: BYTE_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      diff_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) diff_q <= diff_d;
    end
  end

  // Events brought out for the checks
  wire ops_equal = (a_i == b_i);
  wire b_is_zero = (b_i == '0);

  AST_EQUAL_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && ops_equal |=> diff_q == '0);                          // R8
  AST_ZERO_B_PASSES_A: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && b_is_zero |=> diff_q == $past(a_i));                 // R4
  AST_STAGE1_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q == $past(valid_i));                                      // R5
endmodule

// File: rtl/sad_lane_tree.sv
module sad_lane_tree #(
  parameter int LANE_W = sad_pkg::LANE_W_DEF,
  parameter int BYTE_W = sad_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [LANE_W-1:0] diff_i,
  output logic [LANE_W-1:0] sum_o
);
  localparam int BYTES = LANE_W / BYTE_W;
  localparam int SUM_W = sad_pkg::lane_sum_width(BYTE_W, LANE_W);
  localparam int NODES = 2 * BYTES - 1;

  // Heap-ordered tree: node i adds nodes 2i+1 and 2i+2; leaves are the bytes.
  // Bottom level forms 16-bit pair sums, next 32-bit, root the 64-bit total.
  logic [SUM_W-1:0] node [NODES];

  for (genvar j = 0; j < BYTES; j++) begin : g_leaf
    assign node[BYTES-1+j] = {{(SUM_W-BYTE_W){1'b0}}, diff_i[j*BYTE_W +: BYTE_W]};
  end
  for (genvar i = 0; i < BYTES - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sum_q <= '0;
    else if (en_i) sum_q <= node[0];
  end

  assign sum_o = {{(LANE_W-SUM_W){1'b0}}, sum_q};

  // Serial reference sum for the check, independent of the tree shape
  function automatic logic [SUM_W-1:0] serial_sum(input logic [LANE_W-1:0] d);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < BYTES; k++) acc = acc + SUM_W'(d[k*BYTE_W +: BYTE_W]);
    return acc;
  endfunction

  wire [SUM_W-1:0] serial_now = serial_sum(diff_i);

  AST_TREE_MATCHES_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> sum_q == $past(serial_now));                            // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= SUM_W'(BYTES * ((1 << BYTE_W) - 1)));                    // R2
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(sum_q));                                       // R7
endmodule

// File: rtl/sad_packed.sv
module sad_packed #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = sad_pkg::LANE_W_DEF,
  parameter int BYTE_W = sad_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  vec_a,
  input  logic [VEC_W-1:0]  vec_b,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_sum
);
  localparam int LANES = VEC_W / LANE_W;

  logic             mid_valid;
  logic [VEC_W-1:0] mid_diff;

  sad_absdiff_stage #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_diff (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(in_valid),
    .a_i    (vec_a),
    .b_i    (vec_b),
    .valid_q(mid_valid),
    .diff_q (mid_diff)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sad_lane_tree #(.LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (mid_valid),
      .diff_i(mid_diff[l*LANE_W +: LANE_W]),
      .sum_o (out_sum[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= mid_valid;
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mid_valid |=> out_valid);                                        // R5
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !mid_valid |=> !out_valid && $stable(out_sum));                  // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !out_valid && out_sum == '0);                         // R6
endmodule

// File: tb/sim_sad_packed.sv
module sim_sad_packed;
  localparam int VW = 128;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [VW-1:0] vec_a = '0, vec_b = '0;
  logic out_valid;
  logic [VW-1:0] out_sum;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sad_packed u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_a(vec_a),
                 .vec_b(vec_b), .out_valid(out_valid), .out_sum(out_sum));

  // Independent model: signed difference, then magnitude, lanes of 64 bits
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r = '0;
    for (int l = 0; l < VW/64; l++) begin
      int s = 0;
      for (int k = 0; k < 8; k++) begin
        int d = int'(a[l*64+k*8 +: 8]) - int'(b[l*64+k*8 +: 8]);
        s += (d < 0) ? -d : d;
      end
      r[l*64 +: 64] = 64'(s);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transaction: drive, wait two edges, return result at a falling edge
  task automatic run_one(input logic [VW-1:0] a, input logic [VW-1:0] b,
                         output logic [VW-1:0] res, output logic v);
    vec_a = a; vec_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    res = out_sum; v = out_valid;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0 && out_sum == '0, "R6", out_sum, '0);
  endtask

  task automatic t_max();
    logic [VW-1:0] r; logic v;
    run_one({16{8'hFF}}, '0, r, v);
    check(v == 1'b1, "R5", VW'(v), VW'(1));
    check(r == {64'd2040, 64'd2040}, "R2", r, {64'd2040, 64'd2040});
  endtask

  task automatic t_swap();
    logic [VW-1:0] r1, r2, a, b; logic v;
    a = 128'h00FF_7F80_0102_FE01_9A3C_55AA_10F0_0ED1;
    b = 128'hFF00_807F_0201_01FE_3C9A_AA55_F010_D10E;
    run_one(a, b, r1, v);
    check(r1 == model(a, b), "R1", r1, model(a, b));
    run_one(b, a, r2, v);
    check(r2 == r1, "R1", r2, r1);
  endtask

  task automatic t_lanes();
    logic [VW-1:0] r; logic v;
    run_one({{8{8'hFF}}, 64'h0}, '0, r, v);
    check(r[63:0] == 64'd0 && r[127:64] == 64'd2040, "R3", r, {64'd2040, 64'd0});
    run_one({64'h0, 64'h0807_0605_0403_0201}, '0, r, v);
    check(r == {64'd0, 64'd36}, "R3", r, {64'd0, 64'd36});
  endtask

  task automatic t_hsum();
    logic [VW-1:0] r, a; logic v;
    a = 128'h8070_6050_4030_2010_0807_0605_0403_0201;
    run_one(a, '0, r, v);
    check(r == {64'd576, 64'd36}, "R4", r, {64'd576, 64'd36});
  endtask

  task automatic t_equal();
    logic [VW-1:0] r, a; logic v;
    a = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
    run_one(a, a, r, v);
    check(r == '0, "R8", r, '0);
  endtask

  task automatic t_stream();
    logic [VW-1:0] p0, p1, p2;
    p0 = 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00;
    p1 = 128'h0F0F_0F0F_F0F0_F0F0_0000_FFFF_1234_5678;
    p2 = 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001;
    vec_a = p0; vec_b = p2; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R5", VW'(out_valid), '0);
    vec_a = p1; vec_b = p0;
    @(negedge clk);
    check(out_valid && out_sum == model(p0, p2), "R5", out_sum, model(p0, p2));
    vec_a = p2; vec_b = p1;
    @(negedge clk);
    check(out_valid && out_sum == model(p1, p0), "R5", out_sum, model(p1, p0));
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_sum == model(p2, p1), "R5", out_sum, model(p2, p1));
    @(negedge clk);
    check(out_valid == 1'b0, "R5", VW'(out_valid), '0);
  endtask

  task automatic t_hold();
    logic [VW-1:0] last;
    last = out_sum;
    vec_a = {16{8'h5A}}; vec_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_sum == last, "R7", out_sum, last);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_sum == '0, "R6", out_sum, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_max();
    t_swap();
    t_lanes();
    t_hsum();
    t_equal();
    t_stream();
    t_hold();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule